// File: doc/BRIEF.md
# Receive Message Match Unit

This block sits at a network endpoint and decides where an incoming put request goes. A request header names a process table, an entry inside that table and a packed match-bit word. The unit reads the head pointer stored for that table entry and follows the linked match list it points to. It looks at one posted descriptor per clock until it finds a descriptor whose match bits agree with the request. Each descriptor can exclude bits from the comparison through an ignore mask.

On a hit, the unit hands the descriptor's buffer base address to a DMA handshake port. If the descriptor asks for events, the unit then posts an event record. If the request header asked for an acknowledgement, the unit finally returns one to the initiator. A request that finds no matching descriptor is handed to an unexpected-message port together with its header. This happens when the list ends, when the list is empty, or when the walk bound is reached. Descriptors and head pointers are posted through a single write port. The unit handles one request at a time.

Top module: `rx_match_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `dma_valid`, `evt_valid`, `ack_valid` and `unx_valid` are all 0. Every head pointer is 0 and every descriptor is invalid.
- R2: A request accepted with `{req_table, req_entry}` starts at the head pointer stored for that pair. Descriptors are examined in list order, and the first one that matches is delivered even when later ones would also match.
- R3: The match word is packed as protocol [19:18], communicator [17:14], sender rank [13:8] and tag [7:0]. A descriptor matches when, for every bit whose ignore-mask bit is 0, its match bit equals the request bit. Mask bits set to 1 are not compared.
- R4: A descriptor whose valid flag is 0 never matches, but the walk still follows its next pointer.
- R5: On a hit, `dma_valid` rises with `dma_addr` equal to the descriptor's base address. Both hold unchanged until `dma_ready` is sampled high.
- R6: After the DMA handshake, an event record is offered only when the hit descriptor's event-enable bit is 1. The record carries the descriptor index, the request match word and the base address, and it holds until `evt_ready`.
- R7: An acknowledgement carrying the request's sender-rank field is offered only when `req_ack` was 1 at acceptance. It comes after the DMA and any event handshake, and it is never offered for an unexpected message.
- R8: Pointer value 0 is null; writes to descriptor 0 are ignored. When the walk reaches a null pointer without a hit, the request appears on the unexpected port with its table, entry and match word, and no DMA is offered. An empty list (head pointer 0) is also treated this way.
- R9: At most `MAX_WALK` descriptors are examined per request. If none of them matches, the request is treated as unexpected, including on a cyclic list. With no stalls, `unx_valid` is visible in the (`MAX_WALK`+1)-th cycle after acceptance.
- R10: `req_ready` is 0 from the cycle after acceptance until the last handshake of the request (DMA, event, acknowledgement or unexpected) has completed. At most one of the four output valids is high at any time.
- R11: A write with `desc_we`=1 stores a head pointer (`desc_head`=1, index `desc_addr`, value `desc_next`) or a descriptor (`desc_head`=0). The write takes effect for requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request header offered |
| req_ready | output | 1 | Unit idle, header accepted when valid |
| req_table | input | TBL_W | Process table index |
| req_entry | input | ENT_W | Entry index within the table |
| req_bits | input | 20 | Packed match word |
| req_ack | input | 1 | Initiator wants an acknowledgement |
| desc_we | input | 1 | Posting write strobe |
| desc_head | input | 1 | 1: write head pointer, 0: write descriptor |
| desc_addr | input | CA_W | Head index {table,entry} or descriptor index |
| desc_valid | input | 1 | Descriptor valid flag |
| desc_bits | input | 20 | Descriptor match bits |
| desc_mask | input | 20 | Descriptor ignore mask (1 = ignore) |
| desc_base | input | ADDR_W | Descriptor buffer base address |
| desc_evt | input | 1 | Descriptor event enable |
| desc_next | input | PTR_W | Next pointer, or head pointer value |
| dma_valid | output | 1 | Delivery request |
| dma_ready | input | 1 | DMA side accepts |
| dma_addr | output | ADDR_W | Destination buffer base |
| evt_valid | output | 1 | Event record offered |
| evt_ready | input | 1 | Event queue accepts |
| evt_elem | output | PTR_W | Index of matched descriptor |
| evt_bits | output | 20 | Match word of the request |
| evt_addr | output | ADDR_W | Buffer base of the delivery |
| ack_valid | output | 1 | Acknowledgement offered |
| ack_ready | input | 1 | Link accepts acknowledgement |
| ack_rank | output | 6 | Sender rank to acknowledge |
| unx_valid | output | 1 | Unexpected message offered |
| unx_ready | input | 1 | Unexpected buffer accepts |
| unx_table | output | TBL_W | Table index of the unexpected request |
| unx_entry | output | ENT_W | Entry index of the unexpected request |
| unx_bits | output | 20 | Match word of the unexpected request |

## Verification
The hardest case to reach from the ports is the walk bound. A list built from normal posts ends at a null pointer long before the bound matters. The stimulus therefore posts two descriptors that point at each other, which gives a list that never ends. It also posts a five-long chain, and the bench probes the descriptor at position `MAX_WALK` (delivered) and the one after it (unexpected). A second hard case is back-pressure in the middle of a request. The bench holds `dma_ready` and `evt_ready` low while it checks that the offered values hold steady. It then checks that the acknowledgement still arrives last.

// File: rtl/rxm_pkg.sv
// Shared constants and types of the receive match unit.
// Assumes the match word layout {protocol, communicator, rank, tag}, MSB first.
package rxm_pkg;
    parameter int PROTO_W   = 2;
    parameter int COMM_W    = 4;
    parameter int RANK_W    = 6;
    parameter int TAG_W     = 8;
    parameter int MB_W      = PROTO_W + COMM_W + RANK_W + TAG_W;
    parameter int TAG_LSB   = 0;
    parameter int RANK_LSB  = TAG_LSB + TAG_W;
    parameter int COMM_LSB  = RANK_LSB + RANK_W;
    parameter int PROTO_LSB = COMM_LSB + COMM_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_DMA,
        ST_EVT,
        ST_ACK,
        ST_UNX
    } mu_state_t;
endpackage

// File: rtl/rxm_head_table.sv
// Head pointer storage: one list-head pointer per {table,entry} slot.
// Assumes a combinational read; a write becomes visible on the next cycle.
module rxm_head_table #(
    parameter int HEAD_W = 4,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HEAD_W-1:0] wr_idx,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [HEAD_W-1:0] rd_idx,
    output logic [PTR_W-1:0]  rd_ptr
);
    localparam int SLOTS = 1 << HEAD_W;

    logic [PTR_W-1:0] head_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Holds the head pointer of slot s; cleared to null at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_q[s] <= '0;
            end else if (wr_en && wr_idx == HEAD_W'(s)) begin
                head_q[s] <= wr_ptr;
            end
        end
    end

    assign rd_ptr = head_q[rd_idx];
endmodule

// File: rtl/rxm_elem_store.sv
// Posted descriptor storage for all match lists.
// Assumes index 0 is the null pointer: its entry is fixed invalid, and writes to it are dropped.
module rxm_elem_store #(
    parameter int PTR_W  = 4,
    parameter int MB_W   = 20,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [MB_W-1:0]   wr_bits,
    input  logic [MB_W-1:0]   wr_mask,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              wr_evt,
    input  logic [PTR_W-1:0]  wr_next,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [MB_W-1:0]   rd_bits,
    output logic [MB_W-1:0]   rd_mask,
    output logic [ADDR_W-1:0] rd_base,
    output logic              rd_evt,
    output logic [PTR_W-1:0]  rd_next
);
    localparam int DEPTH = 1 << PTR_W;

    logic              vld_q  [DEPTH];
    logic [MB_W-1:0]   bits_q [DEPTH];
    logic [MB_W-1:0]   mask_q [DEPTH];
    logic [ADDR_W-1:0] base_q [DEPTH];
    logic              evt_q  [DEPTH];
    logic [PTR_W-1:0]  next_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_elem
        if (e == 0) begin : g_null
            assign vld_q[e]  = 1'b0;
            assign bits_q[e] = '0;
            assign mask_q[e] = '0;
            assign base_q[e] = '0;
            assign evt_q[e]  = 1'b0;
            assign next_q[e] = '0;
        end else begin : g_real
            // Captures a posted descriptor for slot e; invalid after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[e]  <= 1'b0;
                    bits_q[e] <= '0;
                    mask_q[e] <= '0;
                    base_q[e] <= '0;
                    evt_q[e]  <= 1'b0;
                    next_q[e] <= '0;
                end else if (wr_en && wr_idx == PTR_W'(e)) begin
                    vld_q[e]  <= wr_valid;
                    bits_q[e] <= wr_bits;
                    mask_q[e] <= wr_mask;
                    base_q[e] <= wr_base;
                    evt_q[e]  <= wr_evt;
                    next_q[e] <= wr_next;
                end
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_bits  = bits_q[rd_idx];
    assign rd_mask  = mask_q[rd_idx];
    assign rd_base  = base_q[rd_idx];
    assign rd_evt   = evt_q[rd_idx];
    assign rd_next  = next_q[rd_idx];
endmodule

// File: rtl/rxm_compare.sv
// Masked match comparator: one agree flag per match-word field, then a total hit.
// Assumes mask bit 1 means "do not compare this bit".
module rxm_compare
    import rxm_pkg::*;
(
    input  logic            elem_valid,
    input  logic [MB_W-1:0] elem_bits,
    input  logic [MB_W-1:0] elem_mask,
    input  logic [MB_W-1:0] req_bits,
    output logic            hit
);
    localparam int NFIELD = 4;
    localparam int FLSB [NFIELD] = '{TAG_LSB, RANK_LSB, COMM_LSB, PROTO_LSB};
    localparam int FWID [NFIELD] = '{TAG_W, RANK_W, COMM_W, PROTO_W};

    logic [MB_W-1:0]   diff;
    logic [NFIELD-1:0] agree;

    assign diff = (elem_bits ^ req_bits) & ~elem_mask;

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign agree[f] = (diff[FLSB[f] +: FWID[f]] == '0);
    end

    assign hit = elem_valid && (&agree);
endmodule

// File: rtl/rxm_ctrl.sv
// Request sequencer: accepts one header, walks the match list, then runs the
// delivery, event and acknowledgement handshakes, or the unexpected handshake.
// Assumes the descriptor read for cur_ptr is combinational, so one descriptor is checked per cycle.
module rxm_ctrl
    import rxm_pkg::*;
#(
    parameter int TBL_W    = 2,
    parameter int ENT_W    = 2,
    parameter int PTR_W    = 4,
    parameter int ADDR_W   = 16,
    parameter int MAX_WALK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TBL_W-1:0]  req_table,
    input  logic [ENT_W-1:0]  req_entry,
    input  logic [MB_W-1:0]   req_bits,
    input  logic              req_ack,
    input  logic [PTR_W-1:0]  head_ptr,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [MB_W-1:0]   cmp_bits,
    input  logic              elem_hit,
    input  logic              elem_evt,
    input  logic [ADDR_W-1:0] elem_base,
    input  logic [PTR_W-1:0]  elem_next,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [PTR_W-1:0]  evt_elem,
    output logic [MB_W-1:0]   evt_bits,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic [RANK_W-1:0] ack_rank,
    output logic              unx_valid,
    input  logic              unx_ready,
    output logic [TBL_W-1:0]  unx_table,
    output logic [ENT_W-1:0]  unx_entry,
    output logic [MB_W-1:0]   unx_bits
);
    localparam int CNT_W = $clog2(MAX_WALK + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAX_WALK - 1);

    mu_state_t         state_q;
    logic [TBL_W-1:0]  tbl_q;
    logic [ENT_W-1:0]  ent_q;
    logic [MB_W-1:0]   bits_q;
    logic              ack_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic              evt_q;
    logic [PTR_W-1:0]  hit_q;
    logic              at_null;

    assign at_null = (ptr_q == '0);

    // Sequencer state, latched header and walk position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tbl_q   <= '0;
            ent_q   <= '0;
            bits_q  <= '0;
            ack_q   <= 1'b0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
            evt_q   <= 1'b0;
            hit_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tbl_q   <= req_table;
                        ent_q   <= req_entry;
                        bits_q  <= req_bits;
                        ack_q   <= req_ack;
                        ptr_q   <= head_ptr;
                        cnt_q   <= '0;
                        state_q <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (at_null) begin
                        state_q <= ST_UNX;
                    end else if (elem_hit) begin
                        base_q  <= elem_base;
                        evt_q   <= elem_evt;
                        hit_q   <= ptr_q;
                        state_q <= ST_DMA;
                    end else if (cnt_q == LAST_STEP) begin
                        state_q <= ST_UNX;
                    end else begin
                        ptr_q <= elem_next;
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DMA: begin
                    if (dma_ready) begin
                        state_q <= evt_q ? ST_EVT : (ack_q ? ST_ACK : ST_IDLE);
                    end
                end
                ST_EVT: begin
                    if (evt_ready) begin
                        state_q <= ack_q ? ST_ACK : ST_IDLE;
                    end
                end
                ST_ACK: begin
                    if (ack_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_UNX: begin
                    if (unx_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the current state and latched values.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        dma_valid = (state_q == ST_DMA);
        evt_valid = (state_q == ST_EVT);
        ack_valid = (state_q == ST_ACK);
        unx_valid = (state_q == ST_UNX);
    end

    assign cur_ptr   = ptr_q;
    assign cmp_bits  = bits_q;
    assign dma_addr  = base_q;
    assign evt_elem  = hit_q;
    assign evt_bits  = bits_q;
    assign evt_addr  = base_q;
    assign ack_rank  = bits_q[RANK_LSB +: RANK_W];
    assign unx_table = tbl_q;
    assign unx_entry = ent_q;
    assign unx_bits  = bits_q;
endmodule

// File: rtl/rx_match_unit.sv
// Top of the receive match unit: head table, descriptor store, comparator and sequencer.
// Assumes posting writes and request traffic may overlap; a write affects later lookups only.
module rx_match_unit
    import rxm_pkg::*;
#(
    parameter int TBL_W    = 2,
    parameter int ENT_W    = 2,
    parameter int PTR_W    = 4,
    parameter int ADDR_W   = 16,
    parameter int MAX_WALK = 4,
    localparam int HEAD_W  = TBL_W + ENT_W,
    localparam int CA_W    = (HEAD_W > PTR_W) ? HEAD_W : PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TBL_W-1:0]  req_table,
    input  logic [ENT_W-1:0]  req_entry,
    input  logic [MB_W-1:0]   req_bits,
    input  logic              req_ack,
    input  logic              desc_we,
    input  logic              desc_head,
    input  logic [CA_W-1:0]   desc_addr,
    input  logic              desc_valid,
    input  logic [MB_W-1:0]   desc_bits,
    input  logic [MB_W-1:0]   desc_mask,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              desc_evt,
    input  logic [PTR_W-1:0]  desc_next,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [PTR_W-1:0]  evt_elem,
    output logic [MB_W-1:0]   evt_bits,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic [RANK_W-1:0] ack_rank,
    output logic              unx_valid,
    input  logic              unx_ready,
    output logic [TBL_W-1:0]  unx_table,
    output logic [ENT_W-1:0]  unx_entry,
    output logic [MB_W-1:0]   unx_bits
);
    logic [PTR_W-1:0]  head_ptr;
    logic [PTR_W-1:0]  cur_ptr;
    logic [MB_W-1:0]   cmp_bits;
    logic              e_valid;
    logic [MB_W-1:0]   e_bits;
    logic [MB_W-1:0]   e_mask;
    logic [ADDR_W-1:0] e_base;
    logic              e_evt;
    logic [PTR_W-1:0]  e_next;
    logic              e_hit;

    rxm_head_table #(.HEAD_W(HEAD_W), .PTR_W(PTR_W)) u_heads (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (desc_we && desc_head),
        .wr_idx (desc_addr[HEAD_W-1:0]),
        .wr_ptr (desc_next),
        .rd_idx ({req_table, req_entry}),
        .rd_ptr (head_ptr)
    );

    rxm_elem_store #(.PTR_W(PTR_W), .MB_W(MB_W), .ADDR_W(ADDR_W)) u_elems (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (desc_we && !desc_head),
        .wr_idx   (desc_addr[PTR_W-1:0]),
        .wr_valid (desc_valid),
        .wr_bits  (desc_bits),
        .wr_mask  (desc_mask),
        .wr_base  (desc_base),
        .wr_evt   (desc_evt),
        .wr_next  (desc_next),
        .rd_idx   (cur_ptr),
        .rd_valid (e_valid),
        .rd_bits  (e_bits),
        .rd_mask  (e_mask),
        .rd_base  (e_base),
        .rd_evt   (e_evt),
        .rd_next  (e_next)
    );

    rxm_compare u_cmp (
        .elem_valid (e_valid),
        .elem_bits  (e_bits),
        .elem_mask  (e_mask),
        .req_bits   (cmp_bits),
        .hit        (e_hit)
    );

    rxm_ctrl #(
        .TBL_W(TBL_W), .ENT_W(ENT_W), .PTR_W(PTR_W),
        .ADDR_W(ADDR_W), .MAX_WALK(MAX_WALK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_table (req_table),
        .req_entry (req_entry),
        .req_bits  (req_bits),
        .req_ack   (req_ack),
        .head_ptr  (head_ptr),
        .cur_ptr   (cur_ptr),
        .cmp_bits  (cmp_bits),
        .elem_hit  (e_hit),
        .elem_evt  (e_evt),
        .elem_base (e_base),
        .elem_next (e_next),
        .dma_valid (dma_valid),
        .dma_ready (dma_ready),
        .dma_addr  (dma_addr),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_elem  (evt_elem),
        .evt_bits  (evt_bits),
        .evt_addr  (evt_addr),
        .ack_valid (ack_valid),
        .ack_ready (ack_ready),
        .ack_rank  (ack_rank),
        .unx_valid (unx_valid),
        .unx_ready (unx_ready),
        .unx_table (unx_table),
        .unx_entry (unx_entry),
        .unx_bits  (unx_bits)
    );
endmodule

// File: rtl/rxm_checker.sv
// Protocol checker for rx_match_unit, attached by bind.
// Assumes it observes only the top-level ports.
module rxm_checker
    import rxm_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MAX_WALK = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              dma_valid,
    input logic              dma_ready,
    input logic [ADDR_W-1:0] dma_addr,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic              ack_valid,
    input logic              ack_ready,
    input logic              unx_valid,
    input logic              unx_ready,
    input logic [MB_W-1:0]   unx_bits
);
    localparam int QW = $clog2(MAX_WALK + 2);

    logic          any_out;
    logic [QW-1:0] quiet_q;

    assign any_out = dma_valid | evt_valid | ack_valid | unx_valid;

    // Counts busy cycles with no output offered, i.e. list-walk cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || req_ready || any_out) begin
            quiet_q <= '0;
        end else if (quiet_q != '1) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_one_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_valid, evt_valid, ack_valid, unx_valid}));

    assert_not_ready_when_offering_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> !req_ready);

    assert_dma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr)));

    assert_event_after_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_valid) |-> $past(dma_valid && dma_ready));

    assert_ack_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> $past((dma_valid && dma_ready) || (evt_valid && evt_ready)));

    assert_unexpected_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unx_valid && !unx_ready) |=> (unx_valid && $stable(unx_bits)));

    assert_walk_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= QW'(MAX_WALK));
endmodule

bind rx_match_unit rxm_checker #(.ADDR_W(ADDR_W), .MAX_WALK(MAX_WALK)) u_rxm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .dma_addr  (dma_addr),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .ack_valid (ack_valid),
    .ack_ready (ack_ready),
    .unx_valid (unx_valid),
    .unx_ready (unx_ready),
    .unx_bits  (unx_bits)
);

// File: tb/rx_match_unit_test.sv
// Scoreboard bench: driver tasks queue expected outputs, the monitor pops and compares them.
module rx_match_unit_test;
    import rxm_pkg::*;

    localparam int TBL_W = 2, ENT_W = 2, PTR_W = 4, ADDR_W = 16, MAX_WALK = 4;
    localparam int CA_W = 4;
    localparam int K_DMA = 0, K_EVT = 1, K_ACK = 2, K_UNX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ack = 1'b0;
    logic [TBL_W-1:0] req_table = '0;
    logic [ENT_W-1:0] req_entry = '0;
    logic [MB_W-1:0] req_bits = '0;
    logic req_ready;
    logic desc_we = 1'b0, desc_head = 1'b0, desc_valid = 1'b0, desc_evt = 1'b0;
    logic [CA_W-1:0] desc_addr = '0;
    logic [MB_W-1:0] desc_bits = '0, desc_mask = '0;
    logic [ADDR_W-1:0] desc_base = '0;
    logic [PTR_W-1:0] desc_next = '0;
    logic dma_valid, evt_valid, ack_valid, unx_valid;
    logic dma_ready = 1'b1, evt_ready = 1'b1, ack_ready = 1'b1, unx_ready = 1'b1;
    logic [ADDR_W-1:0] dma_addr, evt_addr;
    logic [PTR_W-1:0] evt_elem;
    logic [MB_W-1:0] evt_bits, unx_bits;
    logic [RANK_W-1:0] ack_rank;
    logic [TBL_W-1:0] unx_table;
    logic [ENT_W-1:0] unx_entry;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    a;
        int    b;
        int    c;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    rx_match_unit #(.TBL_W(TBL_W), .ENT_W(ENT_W), .PTR_W(PTR_W),
                    .ADDR_W(ADDR_W), .MAX_WALK(MAX_WALK)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_table(req_table),
        .req_entry(req_entry), .req_bits(req_bits), .req_ack(req_ack),
        .desc_we(desc_we), .desc_head(desc_head), .desc_addr(desc_addr),
        .desc_valid(desc_valid), .desc_bits(desc_bits), .desc_mask(desc_mask),
        .desc_base(desc_base), .desc_evt(desc_evt), .desc_next(desc_next),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_elem(evt_elem),
        .evt_bits(evt_bits), .evt_addr(evt_addr),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_rank(ack_rank),
        .unx_valid(unx_valid), .unx_ready(unx_ready), .unx_table(unx_table),
        .unx_entry(unx_entry), .unx_bits(unx_bits)
    );

    function automatic logic [MB_W-1:0] mk(int p, int cm, int rk, int tg);
        return {PROTO_W'(p), COMM_W'(cm), RANK_W'(rk), TAG_W'(tg)};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(int kind, int a, int b, int c, string req);
        exp_t e;
        e.kind = kind; e.a = a; e.b = b; e.c = c; e.req = req;
        sb_q.push_back(e);
    endtask

    // Compare one observed handshake against the head of the scoreboard.
    task automatic observe(int kind, int a, int b, int c);
        exp_t e;
        check("R10 ready low during output", int'(req_ready), 0);
        if (sb_q.size() == 0) begin
            check("R6/R7/R8 no output expected, kind", kind, -1);
            return;
        end
        e = sb_q.pop_front();
        check({e.req, " kind"}, kind, e.kind);
        check({e.req, " field a"}, a, e.a);
        check({e.req, " field b"}, b, e.b);
        check({e.req, " field c"}, c, e.c);
    endtask

    // Monitor: samples handshakes at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dma_valid && dma_ready) observe(K_DMA, int'(dma_addr), 0, 0);
            if (evt_valid && evt_ready) observe(K_EVT, int'(evt_elem), int'(evt_bits), int'(evt_addr));
            if (ack_valid && ack_ready) observe(K_ACK, int'(ack_rank), 0, 0);
            if (unx_valid && unx_ready) observe(K_UNX, int'(unx_table), int'(unx_entry), int'(unx_bits));
        end
    end

    task automatic wr_elem(int idx, bit v, logic [MB_W-1:0] b, logic [MB_W-1:0] m,
                           int base, bit ev, int nxt);
        @(posedge clk); #1;
        desc_we = 1; desc_head = 0; desc_addr = CA_W'(idx); desc_valid = v;
        desc_bits = b; desc_mask = m; desc_base = ADDR_W'(base); desc_evt = ev;
        desc_next = PTR_W'(nxt);
        @(posedge clk); #1;
        desc_we = 0;
    endtask

    task automatic wr_head(int tbl, int ent, int ptr);
        @(posedge clk); #1;
        desc_we = 1; desc_head = 1; desc_addr = {TBL_W'(tbl), ENT_W'(ent)};
        desc_next = PTR_W'(ptr);
        @(posedge clk); #1;
        desc_we = 0;
    endtask

    // Present one header; returns after the accepting edge.
    task automatic send(int tbl, int ent, logic [MB_W-1:0] b, bit ack);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_table = TBL_W'(tbl); req_entry = ENT_W'(ent);
        req_bits = b; req_ack = ack;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        @(negedge clk);
        while ((sb_q.size() != 0 || !req_ready) && n < 300) begin
            @(negedge clk);
            n++;
        end
        check({req, " completed, queue left"}, sb_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    logic [MB_W-1:0] va, vb, vc, vd, ve, vf;

    initial begin
        va = mk(1, 3, 5, 'h11); vb = mk(2, 3, 5, 'h22); vc = mk(3, 3, 5, 'h33);
        vd = mk(1, 1, 1, 1);    ve = mk(2, 2, 2, 2);    vf = mk(3, 3, 3, 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 req_ready", int'(req_ready), 1);
        check("R1 output valids", int'({dma_valid, evt_valid, ack_valid, unx_valid}), 0);

        // R11: post lists
        wr_elem(1, 1, va, '0, 'h100, 0, 2);
        wr_elem(2, 1, vb, '0, 'h200, 1, 0);
        wr_head(0, 0, 1);
        wr_elem(3, 1, mk(0, 2, 9, 0), 20'h000FF, 'h300, 0, 0);
        wr_head(1, 2, 3);
        wr_elem(4, 0, vd, '0, 'h400, 0, 5);
        wr_elem(5, 1, vd, '0, 'h500, 0, 0);
        wr_head(2, 1, 4);
        wr_elem(6, 1, ve, '0, 'h600, 0, 7);
        wr_elem(7, 1, ve, '0, 'h700, 0, 0);
        wr_head(3, 3, 6);
        wr_elem(8, 1, vf, '0, 'h800, 0, 9);
        wr_elem(9, 1, vf, '0, 'h900, 0, 8);
        wr_head(2, 3, 8);
        for (int k = 10; k <= 14; k++)
            wr_elem(k, 1, mk(1, 0, k, 'h40 + k), '0, 'h1000 + k * 16, 0, (k == 14) ? 0 : k + 1);
        wr_head(0, 1, 10);
        wr_elem(0, 1, vc, '0, 'hEEE, 1, 1);  // R8: write to null slot is dropped

        // R2/R6: second element, events enabled, no ack
        push(K_DMA, 'h200, 0, 0, "R2 walk to second");
        push(K_EVT, 2, int'(vb), 'h200, "R6 event record");
        send(0, 0, vb, 0); wait_done("R2");

        // R6/R7: first element, no event, ack requested
        push(K_DMA, 'h100, 0, 0, "R2 first element");
        push(K_ACK, 5, 0, 0, "R7 ack rank");
        send(0, 0, va, 1); wait_done("R7");

        // R8: no match reaches null; ack must not appear
        push(K_UNX, 0, 0, int'(vc), "R8 list end unexpected");
        send(0, 0, vc, 1); wait_done("R8");

        // R3: masked tag matches, rank mismatch does not
        push(K_DMA, 'h300, 0, 0, "R3 masked tag hit");
        send(1, 2, mk(0, 2, 9, 'h5A), 0); wait_done("R3 hit");
        push(K_UNX, 1, 2, int'(mk(0, 2, 10, 'h5A)), "R3 rank mismatch");
        send(1, 2, mk(0, 2, 10, 'h5A), 0); wait_done("R3 miss");

        // R4: invalid element skipped
        push(K_DMA, 'h500, 0, 0, "R4 skip invalid");
        push(K_ACK, 1, 0, 0, "R7 ack after skip");
        send(2, 1, vd, 1); wait_done("R4");

        // R2: first of two matches wins
        push(K_DMA, 'h600, 0, 0, "R2 first match wins");
        send(3, 3, ve, 0); wait_done("R2 order");

        // R8: empty list
        push(K_UNX, 3, 0, int'(ve), "R8 empty list");
        send(3, 0, ve, 1); wait_done("R8 empty");

        // R9: cyclic list stops at the bound, with exact latency
        push(K_UNX, 2, 3, int'(mk(3, 3, 3, 4)), "R9 cyclic bound");
        send(2, 3, mk(3, 3, 3, 4), 0);
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!unx_valid && n < 20);
            check("R9 unexpected latency", n, MAX_WALK + 1);
        end
        wait_done("R9 cyclic");

        // R9: element at position MAX_WALK delivered, next one is beyond the bound
        push(K_DMA, 'h1000 + 13 * 16, 0, 0, "R9 last examined hit");
        send(0, 1, mk(1, 0, 13, 'h40 + 13), 0); wait_done("R9 in bound");
        push(K_UNX, 0, 1, int'(mk(1, 0, 14, 'h40 + 14)), "R9 beyond bound");
        send(0, 1, mk(1, 0, 14, 'h40 + 14), 0); wait_done("R9 beyond");

        // R5/R6/R7: back-pressure on delivery and event
        dma_ready = 0; evt_ready = 0;
        push(K_DMA, 'h200, 0, 0, "R5 stalled delivery");
        push(K_EVT, 2, int'(vb), 'h200, "R6 stalled event");
        push(K_ACK, 5, 0, 0, "R7 ack after event");
        send(0, 0, vb, 1);
        while (!dma_valid) @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            check("R5 dma_valid held", int'(dma_valid), 1);
            check("R5 dma_addr held", int'(dma_addr), 'h200);
        end
        @(posedge clk); #1 dma_ready = 1;
        while (!evt_valid) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check("R6 evt_valid held", int'(evt_valid), 1);
            check("R10 no ack before event", int'(ack_valid), 0);
        end
        @(posedge clk); #1 evt_ready = 1;
        wait_done("R5 stall");

        // R11: rewritten descriptor used by the next request
        wr_elem(2, 1, vb, '0, 'h2A0, 0, 0);
        push(K_DMA, 'h2A0, 0, 0, "R11 rewritten descriptor");
        send(0, 0, vb, 0); wait_done("R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule